// File: doc/BRIEF.md
# Exclusive Two-Level LRU Tag Controller

This block tracks which memory blocks sit in a small first-level cache and a larger second-level cache that together behave exclusively: a block lives in at most one level at a time. It holds only tags, valid bits and per-set recency state. It never holds data. A requester hands it one 32-bit load or store address at a time. The controller splits the address into tag, set index and byte offset and searches the first level. On a first-level miss it searches the second level. It then moves blocks between the levels as the exclusive policy requires.

The second level works as a victim store. A block pushed out of the first level to make room goes into the second level. If the target second-level set is full, its least recently used block is dropped. A second-level hit moves the block up into the first level and removes it from the second. A miss in both levels brings the block in from backing memory, which is modelled as a fixed delay, and installs it in the first level only.

Each request ends with a one-cycle response that reports where the block was found. The response arrives after a delay equal to the sum of the programmable latencies of every level the request visited. Four event counters record accesses and misses for each level, so that per-level miss rates can be derived.

Top module: `excl_cache_ctrl`

## Requirements
- R1: After synchronous reset, req_ready is 1, resp_valid is 0, all four counters read 0 and both levels are empty, so the next request reports level code 2.
- R2: A request whose block is present in the first level reports level code 0 (2'd0). The response pulse comes exactly lat_l1 clock edges after the accepting edge, and that block becomes the most recently used block of its first-level set.
- R3: A request that misses the first level and hits the second reports level code 1 after lat_l1+lat_l2 edges. The block is then present in the first level and absent from the second, so an immediate repeat reports code 0.
- R4: A request that misses both levels reports level code 2 after lat_l1+lat_l2+lat_mem edges, and the block is installed in the first level only. Code 3 never appears.
- R5: When a first-level install finds its set full, the least recently used block of that set is moved into the second level, so a later request for it reports code 1 (if it has not been dropped since).
- R6: When a second-level set is full and receives an evicted block, its least recently used block is discarded, so a later request for that block reports code 2.
- R7: Within a set, an empty way is always filled before any block is evicted, and a hit protects the hit block from the next eviction in that set.
- R8: At most one request is outstanding. req_ready stays 0 from the accepting edge until the response has been issued and all tag moves are done, and req_valid asserted while busy is not accepted.
- R9: l1_access_cnt counts requests, l1_miss_cnt counts those with code 1 or 2, l2_access_cnt counts first-level misses and l2_miss_cnt counts code-2 requests. Each counter rises by at most 1 per cycle.
- R10: The low log2(BLK_BYTES) address bits and req_write have no effect on lookup or placement. Addresses that differ only in tag bits above the set index are distinct blocks.
- R11: resp_valid is a single-cycle pulse, one per accepted request, and resp_level is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | 1 for store, 0 for load (no effect on placement) |
| lat_l1 | input | LAT_W | First-level access latency in cycles |
| lat_l2 | input | LAT_W | Second-level access latency in cycles |
| lat_mem | input | LAT_W | Backing-memory latency in cycles |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_level | output | 2 | 0 first level, 1 second level, 2 memory |
| l1_access_cnt | output | CNT_W | First-level lookups |
| l1_miss_cnt | output | CNT_W | First-level misses |
| l2_access_cnt | output | CNT_W | Second-level lookups |
| l2_miss_cnt | output | CNT_W | Second-level misses |

## Verification
Any corruption of tags, valid bits or recency ages appears at the ports as a wrong level code, with the latency to match. It shows on the first later request that maps to the damaged set, and often only after the eviction that the bad state misdirects. A block that wrongly stays in both levels, or a wrong victim choice, shows when the displaced block is requested again: the code is 1 where 2 is due, or the reverse. The bench therefore compares every response, and its exact arrival edge, against an independent most-recently-used list model. It runs sequential, conflicting and pseudo-random address streams under three latency settings, with directed eviction chains that expose each ordering rule.

// File: rtl/excl_cache_pkg.sv
package excl_cache_pkg;

  // Level codes reported on resp_level
  localparam logic [1:0] LVL_NEAR = 2'd0;
  localparam logic [1:0] LVL_FAR  = 2'd1;
  localparam logic [1:0] LVL_MEM  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_NEAR  = 3'd1,
    ST_FAR   = 3'd2,
    ST_FILL  = 3'd3,
    ST_SPILL = 3'd4,
    ST_DONE  = 3'd5
  } ctrl_st_e;

endpackage

// File: rtl/excl_tag_level.sv
// One set-associative tag level with age-based recency.
module excl_tag_level #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  parameter int BA_W = 28
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BA_W-1:0] baddr,
  input  logic            touch_en,
  input  logic            inval_en,
  input  logic            ins_en,
  output logic            hit,
  output logic            vic_valid,
  output logic [BA_W-1:0] vic_baddr
);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = BA_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int AGE_W = WAY_W;
  localparam logic [AGE_W-1:0] AGE_OLDEST = AGE_W'(WAYS - 1);

  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [AGE_W-1:0] age_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];

  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] tag_in;
  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] vic_way;
  logic             found_free;

  assign set_idx = baddr[IDX_W-1:0];
  assign tag_in  = baddr[BA_W-1:IDX_W];

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[set_idx][g] && (tag_q[set_idx][g] == tag_in);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  // Victim: lowest empty way, else the way carrying the oldest age
  always_comb begin
    vic_way    = '0;
    found_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_q[set_idx][w]) begin
        vic_way    = WAY_W'(w);
        found_free = 1'b1;
      end
    end
    if (!found_free) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[set_idx][w] == AGE_OLDEST) vic_way = WAY_W'(w);
      end
    end
  end

  assign vic_valid = !found_free;
  assign vic_baddr = {tag_q[set_idx][vic_way], set_idx};

  // Tag array: no reset, single write port
  always_ff @(posedge clk) begin
    if (!rst && ins_en) tag_q[set_idx][vic_way] <= tag_in;
  end

  // Valid bits and ages
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= '0;
      end
    end else if (touch_en && hit) begin
      for (int w = 0; w < WAYS; w++) begin
        if (valid_q[set_idx][w] && (age_q[set_idx][w] < age_q[set_idx][hit_way]))
          age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
      end
      age_q[set_idx][hit_way] <= '0;
    end else if (inval_en && hit) begin
      for (int w = 0; w < WAYS; w++) begin
        if (valid_q[set_idx][w] && (age_q[set_idx][w] > age_q[set_idx][hit_way]))
          age_q[set_idx][w] <= age_q[set_idx][w] - 1'b1;
      end
      valid_q[set_idx][hit_way] <= 1'b0;
    end else if (ins_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if ((WAY_W'(w) != vic_way) && valid_q[set_idx][w] &&
            (found_free || (age_q[set_idx][w] < age_q[set_idx][vic_way])))
          age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
      end
      valid_q[set_idx][vic_way] <= 1'b1;
      age_q[set_idx][vic_way]   <= '0;
    end
  end

endmodule

// File: rtl/excl_resp_timer.sv
// Counts edges since acceptance and issues the completion pulse.
module excl_resp_timer #(
  parameter int SUM_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             busy,
  input  logic             tgt_valid,
  input  logic [SUM_W-1:0] tgt,
  input  logic [1:0]       lvl,
  output logic             fire,
  output logic             sent,
  output logic             resp_valid,
  output logic [1:0]       resp_level
);
  logic [SUM_W-1:0] elapsed_q;
  logic [SUM_W-1:0] tgt_q;
  logic [1:0]       lvl_q;
  logic             tgt_ok_q;
  logic             sent_q;
  logic [SUM_W-1:0] tgt_eff;
  logic             ok_eff;

  assign tgt_eff = tgt_valid ? tgt : tgt_q;
  assign ok_eff  = tgt_valid || tgt_ok_q;
  assign fire    = busy && !sent_q && ok_eff &&
                   (({1'b0, elapsed_q} + 1'b1) >= {1'b0, tgt_eff});
  assign sent    = sent_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed_q  <= '0;
      tgt_q      <= '0;
      lvl_q      <= '0;
      tgt_ok_q   <= 1'b0;
      sent_q     <= 1'b0;
      resp_valid <= 1'b0;
      resp_level <= '0;
    end else begin
      resp_valid <= fire;
      if (fire) resp_level <= tgt_valid ? lvl : lvl_q;
      if (start) begin
        elapsed_q <= '0;
        tgt_ok_q  <= 1'b0;
        sent_q    <= 1'b0;
      end else if (busy) begin
        if (elapsed_q != '1) elapsed_q <= elapsed_q + 1'b1;
        if (tgt_valid) begin
          tgt_q    <= tgt;
          lvl_q    <= lvl;
          tgt_ok_q <= 1'b1;
        end
        if (fire) sent_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/excl_evt_counter.sv
module excl_evt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/excl_cache_ctrl.sv
module excl_cache_ctrl
  import excl_cache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 16,
  parameter int L1_SETS   = 4,
  parameter int L1_WAYS   = 2,
  parameter int L2_SETS   = 8,
  parameter int L2_WAYS   = 4,
  parameter int LAT_W     = 8,
  parameter int CNT_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [LAT_W-1:0]  lat_l1,
  input  logic [LAT_W-1:0]  lat_l2,
  input  logic [LAT_W-1:0]  lat_mem,
  output logic              resp_valid,
  output logic [1:0]        resp_level,
  output logic [CNT_W-1:0]  l1_access_cnt,
  output logic [CNT_W-1:0]  l1_miss_cnt,
  output logic [CNT_W-1:0]  l2_access_cnt,
  output logic [CNT_W-1:0]  l2_miss_cnt
);
  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int BA_W  = ADDR_W - OFF_W;
  localparam int SUM_W = LAT_W + 2;
  localparam int N_EVT = 4;

  ctrl_st_e         st_q, st_d;
  logic [BA_W-1:0]  baddr_q;
  logic [BA_W-1:0]  vic_q;
  logic [BA_W-1:0]  l2_addr;
  logic             accept;
  logic             work_done;

  logic             l1_hit, l1_vic_valid;
  logic [BA_W-1:0]  l1_vic_baddr;
  logic             l2_hit, l2_vic_valid;
  logic [BA_W-1:0]  l2_vic_baddr;

  logic             tgt_valid;
  logic [SUM_W-1:0] tgt;
  logic [1:0]       lvl;
  logic             t_fire, t_sent;

  logic [N_EVT-1:0] evt;
  logic [CNT_W-1:0] cnt_arr [N_EVT];

  logic unused_bits;
  assign unused_bits = ^{req_addr[OFF_W-1:0], req_write, l2_vic_valid, l2_vic_baddr};

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign l2_addr   = (st_q == ST_SPILL) ? vic_q : baddr_q;

  excl_tag_level #(.SETS(L1_SETS), .WAYS(L1_WAYS), .BA_W(BA_W)) u_near (
    .clk       (clk),
    .rst       (rst),
    .baddr     (baddr_q),
    .touch_en  (st_q == ST_NEAR),
    .inval_en  (1'b0),
    .ins_en    (st_q == ST_FILL),
    .hit       (l1_hit),
    .vic_valid (l1_vic_valid),
    .vic_baddr (l1_vic_baddr)
  );

  excl_tag_level #(.SETS(L2_SETS), .WAYS(L2_WAYS), .BA_W(BA_W)) u_far (
    .clk       (clk),
    .rst       (rst),
    .baddr     (l2_addr),
    .touch_en  (1'b0),
    .inval_en  (st_q == ST_FAR),
    .ins_en    (st_q == ST_SPILL),
    .hit       (l2_hit),
    .vic_valid (l2_vic_valid),
    .vic_baddr (l2_vic_baddr)
  );

  // Latency target becomes known at the lookup that decides the level
  always_comb begin
    tgt_valid = 1'b0;
    tgt       = SUM_W'(lat_l1);
    lvl       = LVL_NEAR;
    if (st_q == ST_NEAR && l1_hit) begin
      tgt_valid = 1'b1;
    end else if (st_q == ST_FAR) begin
      tgt_valid = 1'b1;
      tgt       = SUM_W'(lat_l1) + SUM_W'(lat_l2) + (l2_hit ? '0 : SUM_W'(lat_mem));
      lvl       = l2_hit ? LVL_FAR : LVL_MEM;
    end
  end

  excl_resp_timer #(.SUM_W(SUM_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .busy       (st_q != ST_IDLE),
    .tgt_valid  (tgt_valid),
    .tgt        (tgt),
    .lvl        (lvl),
    .fire       (t_fire),
    .sent       (t_sent),
    .resp_valid (resp_valid),
    .resp_level (resp_level)
  );

  always_comb begin
    st_d      = st_q;
    work_done = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (req_valid) st_d = ST_NEAR;
      ST_NEAR:  if (l1_hit) work_done = 1'b1; else st_d = ST_FAR;
      ST_FAR:   st_d = ST_FILL;
      ST_FILL:  if (l1_vic_valid) st_d = ST_SPILL; else work_done = 1'b1;
      ST_SPILL: work_done = 1'b1;
      ST_DONE:  work_done = 1'b1;
      default:  st_d = ST_IDLE;
    endcase
    if (work_done) st_d = (t_sent || t_fire) ? ST_IDLE : ST_DONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      baddr_q <= '0;
      vic_q   <= '0;
    end else begin
      st_q <= st_d;
      if (accept) baddr_q <= req_addr[ADDR_W-1:OFF_W];
      if (st_q == ST_FILL) vic_q <= l1_vic_baddr;
    end
  end

  assign evt[0] = (st_q == ST_NEAR);
  assign evt[1] = (st_q == ST_NEAR) && !l1_hit;
  assign evt[2] = (st_q == ST_FAR);
  assign evt[3] = (st_q == ST_FAR) && !l2_hit;

  for (genvar e = 0; e < N_EVT; e++) begin : g_cnt
    excl_evt_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (evt[e]),
      .count (cnt_arr[e])
    );
  end

  assign l1_access_cnt = cnt_arr[0];
  assign l1_miss_cnt   = cnt_arr[1];
  assign l2_access_cnt = cnt_arr[2];
  assign l2_miss_cnt   = cnt_arr[3];

endmodule

// File: rtl/excl_cache_ctrl_chk.sv
module excl_cache_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             resp_valid,
  input logic [1:0]       resp_level,
  input logic [CNT_W-1:0] l1_access_cnt,
  input logic [CNT_W-1:0] l1_miss_cnt,
  input logic [CNT_W-1:0] l2_access_cnt,
  input logic [CNT_W-1:0] l2_miss_cnt
);
  AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid); // R11

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R8

  AST_RESP_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(!req_ready)); // R8

  AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (resp_level != 2'd3)); // R4

  AST_L1_MISS_BOUND: assert property (@(posedge clk) disable iff (rst)
    l1_miss_cnt <= l1_access_cnt); // R9

  AST_L2_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
    l2_access_cnt <= l1_miss_cnt); // R9

  AST_L2_MISS_BOUND: assert property (@(posedge clk) disable iff (rst)
    l2_miss_cnt <= l2_access_cnt); // R9

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    (l1_access_cnt == $past(l1_access_cnt)) ||
    (l1_access_cnt == $past(l1_access_cnt) + 1'b1)); // R9
endmodule

bind excl_cache_ctrl excl_cache_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .resp_valid    (resp_valid),
  .resp_level    (resp_level),
  .l1_access_cnt (l1_access_cnt),
  .l1_miss_cnt   (l1_miss_cnt),
  .l2_access_cnt (l2_access_cnt),
  .l2_miss_cnt   (l2_miss_cnt)
);

// File: tb/excl_cache_ctrl_tb.sv
module excl_cache_ctrl_tb;
  localparam int L1S = 4;
  localparam int L1W = 2;
  localparam int L2S = 8;
  localparam int L2W = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  lat_l1 = 8'd2, lat_l2 = 8'd3, lat_mem = 8'd5;
  logic        resp_valid;
  logic [1:0]  resp_level;
  logic [31:0] l1_access_cnt, l1_miss_cnt, l2_access_cnt, l2_miss_cnt;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model: MRU-first lists per set
  logic [27:0] m1 [L1S][L1W];
  int          c1 [L1S];
  logic [27:0] m2 [L2S][L2W];
  int          c2 [L2S];
  int e_l1a, e_l1m, e_l2a, e_l2m;
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  excl_cache_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write),
    .lat_l1(lat_l1), .lat_l2(lat_l2), .lat_mem(lat_mem),
    .resp_valid(resp_valid), .resp_level(resp_level),
    .l1_access_cnt(l1_access_cnt), .l1_miss_cnt(l1_miss_cnt),
    .l2_access_cnt(l2_access_cnt), .l2_miss_cnt(l2_miss_cnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < L1S; s++) c1[s] = 0;
    for (int s = 0; s < L2S; s++) c2[s] = 0;
    e_l1a = 0; e_l1m = 0; e_l2a = 0; e_l2m = 0;
  endtask

  task automatic model_access(input logic [27:0] b, output int code);
    int s1, s2, p;
    logic [27:0] vic;
    bit hv;
    s1 = int'(b % 28'(L1S));
    e_l1a++;
    p = -1;
    for (int i = 0; i < c1[s1]; i++) if (m1[s1][i] == b) p = i;
    if (p >= 0) begin
      for (int i = p; i > 0; i--) m1[s1][i] = m1[s1][i-1];
      m1[s1][0] = b;
      code = 0;
      return;
    end
    e_l1m++; e_l2a++;
    s2 = int'(b % 28'(L2S));
    p = -1;
    for (int i = 0; i < c2[s2]; i++) if (m2[s2][i] == b) p = i;
    if (p >= 0) begin
      for (int i = p; i < c2[s2] - 1; i++) m2[s2][i] = m2[s2][i+1];
      c2[s2]--;
      code = 1;
    end else begin
      e_l2m++;
      code = 2;
    end
    hv = 0; vic = '0;
    if (c1[s1] == L1W) begin vic = m1[s1][L1W-1]; hv = 1; c1[s1]--; end
    for (int i = c1[s1]; i > 0; i--) m1[s1][i] = m1[s1][i-1];
    m1[s1][0] = b; c1[s1]++;
    if (hv) begin
      s2 = int'(vic % 28'(L2S));
      if (c2[s2] == L2W) c2[s2]--;
      for (int i = c2[s2]; i > 0; i--) m2[s2][i] = m2[s2][i-1];
      m2[s2][0] = vic; c2[s2]++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  // tag: requirement named for an expectation-specific check
  task automatic do_req(input logic [31:0] addr, input logic wr, input bit junk, input string tag);
    int code_exp, t_exp, cnt;
    bit got, rdy_bad;
    string rq;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_write = wr;
    model_access(addr[31:4], code_exp);
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 1; got = 0; rdy_bad = 0;
    while (!got && cnt < 3000) begin
      if (resp_valid) got = 1;
      else begin
        if (req_ready) rdy_bad = 1;
        req_valid = junk;               // never accepted: ready is low at this edge
        req_addr  = addr ^ 32'h0100_0000;
        @(negedge clk);
        cnt++;
      end
    end
    req_valid = 1'b0;
    t_exp = (code_exp == 0) ? int'(lat_l1) :
            (code_exp == 1) ? int'(lat_l1) + int'(lat_l2) :
                              int'(lat_l1) + int'(lat_l2) + int'(lat_mem);
    rq = (code_exp == 0) ? "R2" : (code_exp == 1) ? "R3" : "R4";
    if (tag != "") rq = tag;
    check(got, {rq, " response"}, int'(got), 1);
    check(int'(resp_level) == code_exp, {rq, " level"}, int'(resp_level), code_exp);
    check(cnt - 1 == t_exp, {rq, " latency"}, cnt - 1, t_exp);
    check(!rdy_bad, "R8 ready low while busy", int'(rdy_bad), 0);
    @(negedge clk);
    check(!resp_valid, "R11 pulse width", int'(resp_valid), 0);
  endtask

  task automatic check_counters();
    check(l1_access_cnt == 32'(e_l1a), "R9 l1 access", int'(l1_access_cnt), e_l1a);
    check(l1_miss_cnt   == 32'(e_l1m), "R9 l1 miss",   int'(l1_miss_cnt),   e_l1m);
    check(l2_access_cnt == 32'(e_l2a), "R9 l2 access", int'(l2_access_cnt), e_l2a);
    check(l2_miss_cnt   == 32'(e_l2m), "R9 l2 miss",   int'(l2_miss_cnt),   e_l2m);
  endtask

  function automatic logic [31:0] blk(input int b);
    return 32'(b) << 4;
  endfunction

  task automatic rand_run(input int n, input bit junk);
    for (int i = 0; i < n; i++) begin
      logic [27:0] b;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      b = 28'(rng % 32'd48) + (rng[16] ? 28'h10000 : 28'h0);
      do_req({b, rng[23:20]}, rng[9], junk, "");
    end
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    check(resp_valid == 1'b0, "R1 resp idle", int'(resp_valid), 0);
    check_counters();
    do_req(blk(3), 1'b0, 1'b0, "R1 empty after reset");

    // R7 / R5: hit protects block 0; block 4 goes to second level
    do_reset();
    do_req(blk(0), 1'b0, 1'b0, "R7 fill first way");
    do_req(blk(4), 1'b0, 1'b0, "R7 fill empty way");
    do_req(blk(0), 1'b0, 1'b0, "R7 hit");
    do_req(blk(8), 1'b0, 1'b0, "R5 evicting miss");
    do_req(blk(0), 1'b0, 1'b0, "R7 protected block");
    do_req(blk(4), 1'b0, 1'b0, "R5 victim found in L2");
    do_req(blk(4), 1'b0, 1'b0, "R3 moved up");

    // R6: five victims into a 4-way second-level set
    do_reset();
    for (int k = 0; k < 7; k++) do_req(blk(8 * k), 1'b0, 1'b0, "R6 chain");
    do_req(blk(0), 1'b0, 1'b0, "R6 discarded block");
    do_req(blk(8), 1'b0, 1'b0, "R6 surviving block");

    // R10: offset and write flag ignored, high tag bits distinguish
    do_reset();
    do_req(32'h0000_1230, 1'b0, 1'b0, "R10 first");
    do_req(32'h0000_123F, 1'b1, 1'b0, "R10 same block other offset");
    do_req(32'h0100_1230, 1'b1, 1'b0, "R10 other tag");
    check_counters();

    // sweeps under three latency settings
    do_reset();
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < 24; b++) do_req(blk(b), 1'(b), 1'b0, "");
    for (int b = 0; b < 40; b += 4) do_req(blk(b), 1'b0, 1'b0, "");
    rand_run(150, 1'b0);
    check_counters();

    lat_l1 = 8'd1; lat_l2 = 8'd1; lat_mem = 8'd1;
    rand_run(150, 1'b0);
    check_counters();

    lat_l1 = 8'd4; lat_l2 = 8'd7; lat_mem = 8'd20;
    rand_run(120, 1'b1);  // R8: requests offered while busy must be ignored
    check_counters();

    do_reset();
    @(negedge clk);
    check(l1_access_cnt == 0 && l2_miss_cnt == 0, "R1 counters cleared", int'(l1_access_cnt), 0);
    do_req(blk(5), 1'b0, 1'b0, "R1 empty after second reset");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule